// File: doc/BRIEF.md
# Two-Wire Register Slave with Broadcast Reset and High-Speed Code Detection

This block is the bus-facing half of a small measurement peripheral. It connects to a two-wire serial bus (I2C). SCL and SDA are sampled with the system clock. The block never drives SCL. It only pulls SDA low, through an output-enable. It answers the fixed 7-bit address 1001000. Depending on the direction bit, it either streams the surrounding logic's result and configuration bytes to the master, or takes one new configuration byte from it.

Beyond normal addressing, the block listens for the broadcast address 00h. After that address, a data byte of 06h raises a one-cycle reset request for the rest of the peripheral. A data byte of 04h is acknowledged quietly, and every other data byte is refused. A first byte of the form 00001xxx is taken as the high-speed master code. The block never acknowledges it. It sets a flag that stays up until the next STOP, so the surrounding logic can switch its timing.

Top module: `i2cs_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `sda_oe`, `cfg_wr`, `rst_req` and `hs_mode` are all 0.
- R2: A first byte whose upper seven bits are 1001000 is acknowledged by pulling SDA low during the ninth clock. Its least significant bit selects the direction: 1 is read, 0 is write.
- R3: A first byte that is not the block's address, not 00h and not 00001xxx is refused by leaving SDA high. The block then drives nothing until the next START.
- R4: In a write, the first data byte is acknowledged and appears on `cfg_wdata` with a one-cycle `cfg_wr` pulse, issued while SCL is low. Later data bytes in the same transfer are refused and cause no pulse.
- R5: A read returns `out_reg[15:8]`, then `out_reg[7:0]`, then `cfg_reg`, each most significant bit first. A 0 bit is sent by pulling SDA low.
- R6: When the master leaves SDA high in the acknowledge slot of a read, the block releases SDA and ignores further clocks until the next START or STOP.
- R7: A master that keeps acknowledging past the configuration byte reads FFh, because SDA stays released.
- R8: After broadcast address 00h, which is always acknowledged, data byte 06h is acknowledged and gives one `rst_req` pulse. 04h is acknowledged with no pulse. Any other value is refused.
- R9: A first byte of 00001xxx is never acknowledged, whatever its low bit is. It sets `hs_mode`, which the next STOP clears. A repeated START while `hs_mode` is set is addressed normally.
- R10: A START during any phase, including the middle of a byte, restarts address reception. A STOP returns the block to idle.
- R11: `sda_oe` only rises while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_reg | input | 16 | Conversion result to be read |
| cfg_reg | input | 8 | Current configuration byte to be read |
| cfg_wr | output | 1 | One-cycle strobe for a received configuration byte |
| cfg_wdata | output | 8 | Received configuration byte |
| rst_req | output | 1 | One-cycle reset request from a broadcast reset |
| hs_mode | output | 1 | High-speed code seen, held until STOP |

## Verification
A pin change takes three clock edges to reach the registered outputs: two synchroniser stages, then the engine register that acts on the detected edge. SCL edges, STOP and START therefore move `sda_oe`, `hs_mode`, `cfg_wr` and `rst_req` three cycles later. The bench master holds every bus phase for four cycles and samples SDA in the middle of each SCL-high phase. This leaves each result at least one settled cycle before it is read. One-cycle strobes are counted on the falling clock edge, so each pulse is seen exactly once, and the counts are compared after the byte that should cause them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_IGN
    } st_t;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_WRITE,
        TK_READ,
        TK_GCALL,
        TK_SPENT
    } tk_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    localparam logic [7:0] GC_ADDR  = 8'h00;
    localparam logic [7:0] GC_RESET = 8'h06;
    localparam logic [7:0] GC_QUIET = 8'h04;

    function automatic logic is_hs_code(input logic [7:0] b);
        return b[7:3] == 5'b00001;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else if (s == 0) chain[s] <= d;
                else chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'b1001000,
    parameter int         OUT_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [OUT_W-1:0] out_reg,
    input  logic [7:0]       cfg_reg,
    output logic             sda_oe,
    output logic             cfg_wr,
    output logic [7:0]       cfg_wdata,
    output logic             rst_req,
    output logic             hs_mode
);
    localparam int OUT_BYTES = OUT_W / 8;
    localparam int IDX_MAX   = OUT_BYTES + 1;
    localparam int IDX_W     = $clog2(IDX_MAX + 1);

    st_t              st;
    tk_t              tk;
    logic [3:0]       cnt;
    logic [7:0]       sh;
    logic             first;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;

    // decision for the byte just shifted in
    logic ack_now, wr_now, gc_rst_now, hs_now;
    tk_t  tk_next;

    always_comb begin
        rd_byte = 8'hFF;
        for (int i = 0; i < OUT_BYTES; i++)
            if (rd_idx == IDX_W'(i)) rd_byte = out_reg[OUT_W-1-8*i -: 8];
        if (rd_idx == IDX_W'(OUT_BYTES)) rd_byte = cfg_reg;
    end

    always_comb begin
        ack_now    = 1'b0;
        wr_now     = 1'b0;
        gc_rst_now = 1'b0;
        hs_now     = 1'b0;
        tk_next    = TK_SPENT;
        if (first) begin
            if (sh[7:1] == SLAVE_ADDR) begin
                ack_now = 1'b1;
                tk_next = sh[0] ? TK_READ : TK_WRITE;
            end else if (sh == GC_ADDR) begin
                ack_now = 1'b1;
                tk_next = TK_GCALL;
            end else if (is_hs_code(sh)) begin
                hs_now = 1'b1;
            end
        end else begin
            case (tk)
                TK_WRITE: begin
                    ack_now = 1'b1;
                    wr_now  = 1'b1;
                end
                TK_GCALL: begin
                    ack_now    = (sh == GC_RESET) || (sh == GC_QUIET);
                    gc_rst_now = (sh == GC_RESET);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            tk        <= TK_NONE;
            cnt       <= '0;
            sh        <= '0;
            first     <= 1'b0;
            rd_idx    <= '0;
            sda_oe    <= 1'b0;
            cfg_wr    <= 1'b0;
            cfg_wdata <= '0;
            rst_req   <= 1'b0;
            hs_mode   <= 1'b0;
        end else begin
            cfg_wr  <= 1'b0;
            rst_req <= 1'b0;
            if (ev.stop) begin
                st      <= ST_IDLE;
                sda_oe  <= 1'b0;
                hs_mode <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_RX;
                tk     <= TK_NONE;
                cnt    <= '0;
                first  <= 1'b1;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise && cnt < 4'd8) begin
                            sh  <= {sh[6:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall && cnt == 4'd8) begin
                            sda_oe    <= ack_now;
                            st        <= ST_ACK;
                            first     <= 1'b0;
                            tk        <= tk_next;
                            cfg_wr    <= wr_now;
                            cfg_wdata <= sh;
                            rst_req   <= gc_rst_now;
                            rd_idx    <= '0;
                            if (hs_now) hs_mode <= 1'b1;
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            if (!sda_oe) begin
                                st <= ST_IGN;
                            end else if (tk == TK_READ) begin
                                st     <= ST_TX;
                                sh     <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                if (rd_idx != IDX_W'(IDX_MAX)) rd_idx <= rd_idx + 1'b1;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b1};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            if (ev.sda) st <= ST_IGN;
                        end else if (ev.fall) begin
                            cnt    <= '0;
                            st     <= ST_TX;
                            sh     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            if (rd_idx != IDX_W'(IDX_MAX)) rd_idx <= rd_idx + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'b1001000,
    parameter int         SYNC_STAGES = 2,
    parameter int         OUT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [OUT_W-1:0] out_reg,
    input  logic [7:0]       cfg_reg,
    output logic             cfg_wr,
    output logic [7:0]       cfg_wdata,
    output logic             rst_req,
    output logic             hs_mode
);
    logic    scl_s, sda_s, stop_det;
    bus_ev_t ev;

    i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
    );

    i2cs_cond u_cond (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .ev(ev)
    );

    assign stop_det = ev.stop;

    i2cs_engine #(.SLAVE_ADDR(SLAVE_ADDR), .OUT_W(OUT_W)) u_eng (
        .clk(clk), .rst(rst), .ev(ev), .out_reg(out_reg), .cfg_reg(cfg_reg),
        .sda_oe(sda_oe), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .rst_req(rst_req), .hs_mode(hs_mode)
    );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic stop_det,
    input logic sda_oe,
    input logic cfg_wr,
    input logic rst_req,
    input logic hs_mode
);
    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q && !rst)
            a_r1_reset_quiet: assert (!sda_oe && !cfg_wr && !rst_req && !hs_mode);
    end

    a_r4_wr_single: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_wr);

    a_r4_wr_scl_low: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> !scl_s);

    a_r8_rst_single: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    a_r9_hs_clear: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !hs_mode);

    a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);
endmodule

bind i2cs_top i2cs_chk u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .stop_det(stop_det),
    .sda_oe(sda_oe), .cfg_wr(cfg_wr), .rst_req(rst_req), .hs_mode(hs_mode)
);

// File: tb/test_i2cs_top.sv
module test_i2cs_top;
    localparam int CLK_P = 10;
    localparam int Q     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe, cfg_wr, rst_req, hs_mode;
    logic [15:0] out_reg = 16'hA55A;
    logic [7:0]  cfg_reg = 8'h3C;
    logic [7:0]  cfg_wdata;

    int checks = 0, fails = 0;
    int wr_cnt = 0, rr_cnt = 0;
    logic [7:0] wr_last = '0;
    logic oe_seen = 1'b0;

    always #(CLK_P/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2cs_top i_i2cs_top (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .out_reg(out_reg), .cfg_reg(cfg_reg), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .rst_req(rst_req), .hs_mode(hs_mode)
    );

    always @(negedge clk) begin
        if (cfg_wr) begin wr_cnt++; wr_last = cfg_wdata; end
        if (rst_req) rr_cnt++;
        if (sda_oe) oe_seen = 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b, output logic seen);
        sda_m = b; tick(Q);
        scl = 1'b1; tick(Q);
        seen = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(b[i], s);
        put_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, s);
            b[i] = s;
        end
        put_bit(!m_ack, s);
    endtask

    task automatic t_reset();
        chk(!sda_oe && !cfg_wr && !rst_req && !hs_mode, "R1 reset outputs",
            {sda_oe, cfg_wr, rst_req, hs_mode}, 0);
    endtask

    task automatic t_write();
        logic a;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h90, a);
        chk(a, "R2 write address ack", a, 1);
        send_byte(8'h8C, a);
        chk(a, "R4 config byte ack", a, 1);
        chk(wr_cnt == w0 + 1 && wr_last == 8'h8C, "R4 config strobe", wr_last, 8'h8C);
        send_byte(8'h21, a);
        chk(!a, "R4 second data byte nack", a, 0);
        chk(wr_cnt == w0 + 1, "R4 no extra strobe", wr_cnt - w0, 1);
        bus_stop();
    endtask

    task automatic t_read_full();
        logic a;
        logic [7:0] b;
        out_reg = 16'hA55A; cfg_reg = 8'h3C;
        bus_start();
        send_byte(8'h91, a);
        chk(a, "R2 read address ack", a, 1);
        recv_byte(1'b1, b); chk(b == 8'hA5, "R5 high byte", b, 8'hA5);
        recv_byte(1'b1, b); chk(b == 8'h5A, "R5 low byte", b, 8'h5A);
        recv_byte(1'b1, b); chk(b == 8'h3C, "R5 config byte", b, 8'h3C);
        recv_byte(1'b1, b); chk(b == 8'hFF, "R7 past end", b, 8'hFF);
        recv_byte(1'b0, b); chk(b == 8'hFF, "R7 past end again", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_read_short();
        logic a;
        logic [7:0] b;
        out_reg = 16'h0F81;
        bus_start();
        send_byte(8'h91, a);
        recv_byte(1'b1, b); chk(b == 8'h0F, "R5 high byte 2", b, 8'h0F);
        recv_byte(1'b0, b); chk(b == 8'h81, "R5 low byte 2", b, 8'h81);
        oe_seen = 1'b0;
        recv_byte(1'b1, b);
        chk(b == 8'hFF && !oe_seen, "R6 released after nack", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic a;
        int w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h92, a);
        chk(!a, "R3 foreign address nack", a, 0);
        oe_seen = 1'b0;
        send_byte(8'h90, a);
        chk(!a && !oe_seen && wr_cnt == w0, "R3 silent after nack", oe_seen, 0);
        bus_stop();
    endtask

    task automatic t_gcall();
        logic a;
        int r0;
        r0 = rr_cnt;
        bus_start();
        send_byte(8'h00, a); chk(a, "R8 broadcast ack", a, 1);
        send_byte(8'h06, a); chk(a, "R8 reset byte ack", a, 1);
        chk(rr_cnt == r0 + 1, "R8 reset pulse", rr_cnt - r0, 1);
        bus_stop();
        bus_start();
        send_byte(8'h00, a);
        send_byte(8'h04, a); chk(a, "R8 quiet byte ack", a, 1);
        chk(rr_cnt == r0 + 1, "R8 no pulse for 04h", rr_cnt - r0, 1);
        bus_stop();
        bus_start();
        send_byte(8'h00, a);
        send_byte(8'h05, a); chk(!a, "R8 other byte nack", a, 0);
        bus_stop();
    endtask

    task automatic t_hs();
        logic a;
        logic [7:0] b;
        out_reg = 16'h3C96;
        bus_start();
        send_byte(8'h0B, a);
        chk(!a, "R9 master code nack", a, 0);
        chk(hs_mode, "R9 flag set", hs_mode, 1);
        bus_start();
        send_byte(8'h91, a);
        chk(a && hs_mode, "R9 addressed in high-speed", {a, hs_mode}, 3);
        recv_byte(1'b0, b);
        chk(b == 8'h3C, "R9 read in high-speed", b, 8'h3C);
        bus_stop();
        chk(!hs_mode, "R9 flag cleared by stop", hs_mode, 0);
        bus_start();
        send_byte(8'h0E, a);
        chk(!a && hs_mode, "R9 code low bit ignored", {a, hs_mode}, 1);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a, s;
        bus_start();
        put_bit(1'b1, s); put_bit(1'b0, s); put_bit(1'b1, s);
        bus_start();
        send_byte(8'h90, a);
        chk(a, "R10 restart mid byte", a, 1);
        bus_stop();
        chk(!sda_oe, "R10 idle after stop", sda_oe, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        rst = 1'b0;
        tick(1);
        t_reset();
        tick(4);
        t_write();
        t_read_full();
        t_read_short();
        t_bad_addr();
        t_gcall();
        t_hs();
        t_restart();
        tick(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule